// File: doc/BRIEF.md
# PLL Bypass Relock Sequencer

This block steps a PLL through a safe reprogramming sequence. The clock output is parked on the bypass source first. The new divider coefficients are applied while the PLL is disabled or has just left its power-down state. The block waits for lock, and the output returns to the VCO only after the synchronizing switch has been armed. The same block also runs an orderly shutdown that leaves the output on bypass with the PLL disabled.

Each step that changes a control output has its own state, so consecutive control changes are at least one clock apart. Time-based waits use a one-microsecond tick input. The wait after releasing power-down is a fixed number of ticks. Lock is polled at a fixed tick spacing, and the number of polls comes from a configured lock delay. If lock never arrives, the sequence stops with the output still on bypass and raises a failure flag. All pins are plain control and status signals, with no streaming handshake.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset, vco_sel, iddq_release, pll_enable, sync_enable and lockdet_power are 0 (0 on vco_sel means bypass). The coefficient outputs are 0, and busy, done and fail are 0.
- R2: In both program and shutdown sequences, the first control output to change is vco_sel, which goes to 0. If go_program and go_shutdown are high in the same idle cycle, the program sequence runs.
- R3: In a program sequence where pd_status is 1 once bypass is selected, iddq_release goes to 1. The coefficients are then written once exactly IDDQ_WAIT_US ticks have been counted after iddq_release rises, and sync_enable and pll_enable are not cleared on this path.
- R4: In a program sequence where pd_status is 0, sync_enable is cleared first and pll_enable is cleared in a later cycle, both before the coefficients are written.
- R5: coef_m, coef_n and the relock post divider are all written in the same cycle, and only while pll_enable is 0.
- R6: pll_enable rises after the coefficient write, while the output is on bypass. lockdet_power is set to 1 in a later cycle.
- R7: lock_ok is sampled once every POLL_GAP_US ticks, for at most LOCK_DELAY_US/2+1 samples (151 with the defaults). If none is high, fail goes to 1 and busy goes to 0 with vco_sel still 0, and done stays low.
- R8: After lock, sync_enable goes to 1, and vco_sel goes to 1 in a later cycle.
- R9: With GLITCHLESS=1, a requested post divider of 0 or 1 is written as 2 during the relock. The requested value is written only after vco_sel has returned to 1. Values of 2 and above are written unchanged at the relock write.
- R10: A shutdown sequence changes vco_sel to 0, then clears sync_enable, then clears pll_enable, each in a separate cycle, and leaves the coefficients unchanged.
- R11: busy is high from the cycle after a start is accepted until the sequence ends. A start strobe that arrives while busy is ignored.
- R12: done is a single-cycle pulse when a sequence completes. fail stays high until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_program | input | 1 | Strobe that starts a relock with the target coefficients |
| go_shutdown | input | 1 | Strobe that starts an orderly shutdown |
| tgt_m | input | M_W | Target reference divider |
| tgt_n | input | N_W | Target feedback divider |
| tgt_pl | input | PL_W | Target post divider |
| lock_ok | input | 1 | PLL lock indicator |
| pd_status | input | 1 | 1 while the PLL is still in its power-down state |
| tick_1us | input | 1 | One-cycle pulse each microsecond |
| vco_sel | output | 1 | Output mux select: 1 VCO, 0 bypass |
| iddq_release | output | 1 | Releases the PLL from power-down |
| pll_enable | output | 1 | PLL enable |
| sync_enable | output | 1 | Arms the synchronizing bypass/VCO switch |
| lockdet_power | output | 1 | Powers the lock detector |
| coef_m | output | M_W | Applied reference divider |
| coef_n | output | N_W | Applied feedback divider |
| coef_pl | output | PL_W | Applied post divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Lock was never seen; held until the next start |

## Verification
The assertions assume three things about the inputs: tick_1us is a one-cycle pulse, start strobes are only meaningful in idle cycles, and lock_ok only rises while the PLL is enabled. The bench produces a tick on every third clock and models lock as a fixed number of cycles after pll_enable rises, or never. It models power-down status as cleared by iddq_release. The bench records the cycle of every output change, so ordering, tick counts between steps and the poll budget can all be compared against the requirements.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BYP, ST_PD_REL, ST_PD_WAIT, ST_SYNC_OFF, ST_DIS,
    ST_COEF, ST_EN, ST_LCKDET, ST_POLL, ST_POLL_WAIT, ST_SYNC_ON,
    ST_VCO, ST_PL, ST_DONE
  } relock_st_e;
endpackage

// File: rtl/pll_relock_tmr.sv
module pll_relock_tmr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3
  tmr_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val != '0);
endmodule

// File: rtl/pll_relock_budget.sv
module pll_relock_budget #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - 1'b1;
  end

  assign last = (left == W'(1));

  // R7
  budget_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> left > W'(1));
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
  import pll_relock_pkg::*;
#(
  parameter int M_W           = 8,
  parameter int N_W           = 8,
  parameter int PL_W          = 5,
  parameter int LOCK_DELAY_US = 300,
  parameter int IDDQ_WAIT_US  = 5,
  parameter int POLL_GAP_US   = 2,
  parameter bit GLITCHLESS    = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_program,
  input  logic            go_shutdown,
  input  logic [M_W-1:0]  tgt_m,
  input  logic [N_W-1:0]  tgt_n,
  input  logic [PL_W-1:0] tgt_pl,
  input  logic            lock_ok,
  input  logic            pd_status,
  input  logic            tick_1us,
  output logic            vco_sel,
  output logic            iddq_release,
  output logic            pll_enable,
  output logic            sync_enable,
  output logic            lockdet_power,
  output logic [M_W-1:0]  coef_m,
  output logic [N_W-1:0]  coef_n,
  output logic [PL_W-1:0] coef_pl,
  output logic            busy,
  output logic            done,
  output logic            fail
);
  localparam int ATTEMPTS = LOCK_DELAY_US / 2 + 1;
  localparam int BUD_W    = $clog2(ATTEMPTS + 1);
  localparam int WAIT_MAX = (IDDQ_WAIT_US > POLL_GAP_US) ? IDDQ_WAIT_US : POLL_GAP_US;
  localparam int TMR_W    = $clog2(WAIT_MAX + 1);

  relock_st_e st;
  logic            op_off;
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [PL_W-1:0] pl_q, pl_relock;
  logic            tmr_load, tmr_exp, bud_load, bud_dec, bud_last;
  logic [TMR_W-1:0] tmr_val;

  generate
    if (GLITCHLESS) begin : g_clamp
      assign pl_relock = (pl_q < PL_W'(2)) ? PL_W'(2) : pl_q;
    end else begin : g_direct
      assign pl_relock = pl_q;
    end
  endgenerate

  assign tmr_load = (st == ST_PD_REL) || (st == ST_POLL && !lock_ok && !bud_last);
  assign tmr_val  = (st == ST_PD_REL) ? TMR_W'(IDDQ_WAIT_US) : TMR_W'(POLL_GAP_US);
  assign bud_load = (st == ST_LCKDET);
  assign bud_dec  = (st == ST_POLL) && !lock_ok && !bud_last;

  pll_relock_tmr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(tick_1us), .expired(tmr_exp));

  pll_relock_budget #(.W(BUD_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(bud_load), .load_val(BUD_W'(ATTEMPTS)),
    .dec(bud_dec), .last(bud_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_off <= 1'b0;
      m_q <= '0; n_q <= '0; pl_q <= '0;
      vco_sel <= 1'b0; iddq_release <= 1'b0; pll_enable <= 1'b0;
      sync_enable <= 1'b0; lockdet_power <= 1'b0;
      coef_m <= '0; coef_n <= '0; coef_pl <= '0;
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (go_program || go_shutdown) begin
          busy <= 1'b1; fail <= 1'b0; op_off <= !go_program;
          m_q <= tgt_m; n_q <= tgt_n; pl_q <= tgt_pl;
          st <= ST_BYP;
        end
        ST_BYP: begin
          vco_sel <= 1'b0;
          st <= (!op_off && pd_status) ? ST_PD_REL : ST_SYNC_OFF;
        end
        ST_PD_REL:  begin iddq_release <= 1'b1; st <= ST_PD_WAIT; end
        ST_PD_WAIT: if (tmr_exp) st <= ST_COEF;
        ST_SYNC_OFF: begin sync_enable <= 1'b0; st <= ST_DIS; end
        ST_DIS: begin
          pll_enable <= 1'b0;
          st <= op_off ? ST_DONE : ST_COEF;
        end
        ST_COEF: begin
          coef_m <= m_q; coef_n <= n_q; coef_pl <= pl_relock;
          st <= ST_EN;
        end
        ST_EN:     begin pll_enable <= 1'b1; st <= ST_LCKDET; end
        ST_LCKDET: begin lockdet_power <= 1'b1; st <= ST_POLL; end
        ST_POLL: begin
          if (lock_ok)       st <= ST_SYNC_ON;
          else if (bud_last) begin fail <= 1'b1; busy <= 1'b0; st <= ST_IDLE; end
          else               st <= ST_POLL_WAIT;
        end
        ST_POLL_WAIT: if (tmr_exp) st <= ST_POLL;
        ST_SYNC_ON: begin sync_enable <= 1'b1; st <= ST_VCO; end
        ST_VCO:     begin vco_sel <= 1'b1; st <= ST_PL; end
        ST_PL:      begin coef_pl <= pl_q; st <= ST_DONE; end
        ST_DONE:    begin done <= 1'b1; busy <= 1'b0; st <= ST_IDLE; end
        default:    st <= ST_IDLE;
      endcase
    end
  end

  // R2
  bypass_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !vco_sel);
  // R4
  sync_clear_before_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_enable) |-> !sync_enable);
  // R5
  coef_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(coef_n) || !$stable(coef_m)) |-> !pll_enable);
  // R6
  enable_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_enable) |-> !vco_sel);
  // R7
  fail_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (!vco_sel && !busy));
  // R8
  sync_before_vco_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_sel) |-> (sync_enable && $past(sync_enable)));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/pll_relock_seq_tb.sv
module pll_relock_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int M_W = 8, N_W = 8, PL_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_program = 1'b0, go_shutdown = 1'b0, tick_1us = 1'b0;
  logic [M_W-1:0] tgt_m = '0;
  logic [N_W-1:0] tgt_n = '0;
  logic [PL_W-1:0] tgt_pl = '0;
  logic lock_mode = 1'b0, pd_model = 1'b1;
  logic lock_ok, pd_status;
  logic vco_sel, iddq_release, pll_enable, sync_enable, lockdet_power;
  logic [M_W-1:0] coef_m;
  logic [N_W-1:0] coef_n;
  logic [PL_W-1:0] coef_pl;
  logic busy, done, fail;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, en_cnt = 0;
  int t_byp, t_sync_off, t_en_off, t_coef, t_en_on, t_lck, t_sync_on, t_vco, t_pl;
  int pl_at_coef, m_at_coef, n_at_coef, pd_ticks, poll_ticks, done_cnt, busy_seen;
  logic p_vco, p_sync, p_en, p_lck;
  logic [M_W-1:0] p_m;
  logic [N_W-1:0] p_n;
  logic [PL_W-1:0] p_pl;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign lock_ok   = lock_mode && (en_cnt >= 8);
  assign pd_status = pd_model && !iddq_release;

  pll_relock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .go_program(go_program), .go_shutdown(go_shutdown),
    .tgt_m(tgt_m), .tgt_n(tgt_n), .tgt_pl(tgt_pl), .lock_ok(lock_ok),
    .pd_status(pd_status), .tick_1us(tick_1us), .vco_sel(vco_sel),
    .iddq_release(iddq_release), .pll_enable(pll_enable), .sync_enable(sync_enable),
    .lockdet_power(lockdet_power), .coef_m(coef_m), .coef_n(coef_n),
    .coef_pl(coef_pl), .busy(busy), .done(done), .fail(fail));

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      tick_1us = (k == 2);
      k = (k == 2) ? 0 : k + 1;
    end
  end

  task automatic clr_stamps();
    t_byp = -1; t_sync_off = -1; t_en_off = -1; t_coef = -1; t_en_on = -1;
    t_lck = -1; t_sync_on = -1; t_vco = -1; t_pl = -1;
    pl_at_coef = -1; m_at_coef = -1; n_at_coef = -1;
    pd_ticks = 0; poll_ticks = 0; done_cnt = 0; busy_seen = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    en_cnt = pll_enable ? en_cnt + 1 : 0;
    if (rst_n) begin
      if (p_vco && !vco_sel)      t_byp = cyc;
      if (!p_vco && vco_sel)      t_vco = cyc;
      if (p_sync && !sync_enable) t_sync_off = cyc;
      if (!p_sync && sync_enable) t_sync_on = cyc;
      if (p_en && !pll_enable)    t_en_off = cyc;
      if (!p_en && pll_enable)    t_en_on = cyc;
      if (!p_lck && lockdet_power) t_lck = cyc;
      if ((coef_n != p_n || coef_m != p_m) && t_coef < 0) begin
        t_coef = cyc; pl_at_coef = coef_pl; m_at_coef = coef_m; n_at_coef = coef_n;
      end else if (coef_pl != p_pl) t_pl = cyc;
      if (tick_1us && iddq_release && t_coef < 0) pd_ticks++;
      if (tick_1us && pll_enable && !fail && !vco_sel) poll_ticks++;
      if (done) done_cnt++;
      if (busy) busy_seen++;
    end
    p_vco = vco_sel; p_sync = sync_enable; p_en = pll_enable; p_lck = lockdet_power;
    p_m = coef_m; p_n = coef_n; p_pl = coef_pl;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input bit prog, input bit off, input int m, input int n, input int pl);
    @(negedge clk);
    tgt_m = M_W'(m); tgt_n = N_W'(n); tgt_pl = PL_W'(pl);
    go_program = prog; go_shutdown = off;
    @(negedge clk);
    go_program = 1'b0; go_shutdown = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || fail) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(vco_sel == 0 && iddq_release == 0 && pll_enable == 0, "R1 controls", 0, 0);
    chk(sync_enable == 0 && lockdet_power == 0, "R1 sync/lockdet", 0, 0);
    chk(coef_m == 0 && coef_n == 0 && coef_pl == 0, "R1 coef", int'(coef_n), 0);
    chk(busy == 0 && done == 0 && fail == 0, "R1 status", int'(busy), 0);
  endtask

  task automatic test_cold_program();
    clr_stamps(); lock_mode = 1'b1;
    start(1'b1, 1'b0, 2, 50, 1);
    wait_end();
    chk(pd_ticks == 5, "R3 ticks before coef write", pd_ticks, 5);
    chk(t_sync_off < 0 && t_en_off < 0, "R3 no clear on cold path", t_en_off, -1);
    chk(m_at_coef == 2 && n_at_coef == 50, "R5 m/n written together", n_at_coef, 50);
    chk(pl_at_coef == 2, "R9 post divider forced to 2", pl_at_coef, 2);
    chk(t_en_on > t_coef && t_lck > t_en_on, "R6 enable then lockdet", t_lck, t_en_on + 1);
    chk(t_vco > t_sync_on && t_sync_on > t_lck, "R8 sync then vco", t_vco, t_sync_on + 1);
    chk(t_pl > t_vco && coef_pl == 1, "R9 target pl after vco", int'(coef_pl), 1);
    chk(done_cnt == 1, "R12 single done pulse", done_cnt, 1);
  endtask

  task automatic test_warm_program_ignore();
    clr_stamps();
    start(1'b1, 1'b0, 3, 80, 4);
    repeat (4) @(negedge clk);
    go_shutdown = 1'b1; @(negedge clk); go_shutdown = 1'b0;
    wait_end();
    chk(t_byp > 0 && t_byp < t_sync_off, "R2 bypass first", t_byp, t_sync_off - 1);
    chk(t_sync_off < t_en_off && t_en_off < t_coef, "R4 sync, enable, coef order", t_en_off, t_coef - 1);
    chk(m_at_coef == 3 && n_at_coef == 80 && pl_at_coef == 4, "R5 R9 coef write", pl_at_coef, 4);
    chk(pll_enable == 1 && vco_sel == 1, "R11 start while busy ignored", int'(pll_enable), 1);
    chk(busy_seen > 10 && busy == 0, "R11 busy span", busy_seen, 11);
  endtask

  task automatic test_shutdown();
    clr_stamps();
    start(1'b0, 1'b1, 9, 9, 9);
    wait_end();
    chk(t_byp > 0 && t_byp < t_sync_off && t_sync_off < t_en_off, "R10 shutdown order", t_sync_off, t_byp + 1);
    chk(vco_sel == 0 && pll_enable == 0 && sync_enable == 0, "R10 final off", int'(pll_enable), 0);
    chk(coef_m == 3 && coef_n == 80 && coef_pl == 4, "R10 coef kept", int'(coef_n), 80);
    chk(done_cnt == 1, "R12 done on shutdown", done_cnt, 1);
  endtask

  task automatic test_both_strobes();
    clr_stamps();
    start(1'b1, 1'b1, 1, 60, 3);
    wait_end();
    chk(pll_enable == 1 && vco_sel == 1 && coef_n == 60, "R2 program priority", int'(coef_n), 60);
  endtask

  task automatic test_lock_fail();
    clr_stamps(); lock_mode = 1'b0;
    start(1'b1, 1'b0, 2, 70, 2);
    wait_end();
    chk(poll_ticks == 300 || poll_ticks == 301, "R7 poll budget ticks", poll_ticks, 300);
    chk(fail == 1 && vco_sel == 0 && busy == 0, "R7 fail in bypass", int'(vco_sel), 0);
    chk(done_cnt == 0, "R7 no done on failure", done_cnt, 0);
    repeat (20) @(negedge clk);
    chk(fail == 1, "R12 fail held", int'(fail), 1);
    lock_mode = 1'b1; clr_stamps();
    start(1'b1, 1'b0, 2, 90, 2);
    chk(fail == 0, "R12 fail cleared by start", int'(fail), 0);
    wait_end();
    chk(done_cnt == 1 && vco_sel == 1, "R12 recovery done", done_cnt, 1);
  endtask

  initial begin
    clr_stamps();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_cold_program();
    test_warm_program_ignore();
    test_shutdown();
    test_both_strobes();
    test_lock_fail();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule